// File: doc/BRIEF.md
# Strobed 64x1 Static RAM

This block is a 64-word by 1-bit read/write store, selected by a six-bit address. It responds only in a clock cycle where the strobe input and both chip-enable inputs are high together. In such a cycle the read/write select picks the operation. Low selects a write: the data input bit is stored in the addressed word at that clock edge. High selects a read: the addressed word is presented on the data output after a fixed access latency.

The output is modelled as a data bit plus an output-enable, standing in for a three-state pin. A read passes through three phases. The output is disabled in the cycle where the read is first sampled. It then drives LOW. Only after that does it show the stored bit, with the same polarity as written. The bench and the notes use these controller states:

- `ST_IDLE`: not selected.
- `ST_WRITE`: a write was just performed.
- `ST_RD_LOW`: the output drives LOW while access time runs.
- `ST_RD_DATA`: the output shows the stored bit.

The controller moves between these states as follows:

- It goes to `ST_IDLE` from any state when any qualifier is low.
- It goes to `ST_WRITE` from any state on a qualified write.
- It goes from `ST_IDLE` or `ST_WRITE` to `ST_RD_LOW` on a qualified read.
- It stays in `ST_RD_LOW` until ACCESS_CYCLES-1 cycles have passed, then goes to `ST_RD_DATA`.
- It holds `ST_RD_DATA` while the read continues on the same address.
- It goes back to `ST_RD_LOW`, with the count restarted, when the address changes during a read.

Storage is not cleared by reset.

Top module: `strobed_ram64`

## Requirements
- R1: The store holds 64 independent single-bit words, each selected by the 6-bit `addr` value, with every address decoded to its own word.
- R2: When any of `stb`, `en_a`, `en_b` is low at a clock edge, no word is changed and `dout_oe` is 0 in the following cycle.
- R3: On a clock edge where `stb`, `en_a` and `en_b` are high and `rd_nwr` is 0, `din` is stored at `addr`, and `dout_oe` is 0 in the following cycle.
- R4: On a clock edge where all three qualifiers are high and `rd_nwr` is 1, `dout_oe` becomes 1 in the following cycle, and it was 0 in the cycle of that first sampling edge when no read preceded it.
- R5: After a read starts, `dout` is 0 with `dout_oe` 1 for ACCESS_CYCLES-1 cycles (default 2, so one cycle). From then on it shows the addressed word while the read is held.
- R6: The read bit equals the bit last written to that address, with no inversion.
- R7: `rd_nwr` may stay low across back-to-back writes, and high across back-to-back reads, with each access taking effect.
- R8: A change of `addr` during a read restarts the LOW phase, so data is shown only for an address held through the full access time.
- R9: While `rst_n` is 0 and in the cycle after its release, `dout_oe` is 0 and `dout` is 0.
- R10: Whenever `dout_oe` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the controller |
| stb | input | 1 | Strobe qualifier |
| en_a | input | 1 | First chip-enable qualifier |
| en_b | input | 1 | Second chip-enable qualifier |
| rd_nwr | input | 1 | 1 selects read, 0 selects write |
| addr | input | 6 | Word address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when not enabled |
| dout_oe | output | 1 | Output enable, stands in for three-state drive |

## Verification
Two functions can fall in the same clock edge. One is a read that reaches its data phase. The other is an address change or a switch to write that ends that read. The bench holds a read until the stored bit appears. In the next cycle it either moves `addr` or drops `rd_nwr` to 0. It then judges three things: the output falls back to LOW or to disabled one cycle later, the new word appears only after a complete LOW phase, and a write made at that edge reads back intact.

// File: rtl/sram64_pkg.sv
package sram64_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_RD_LOW  = 2'd2,
        ST_RD_DATA = 2'd3
    } acc_state_t;
endpackage

// File: rtl/sram64_array.sv
module sram64_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] cells;

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wbit;
    end

    assign rbit = cells[raddr];
endmodule

// File: rtl/sram64_ctrl.sv
module sram64_ctrl
    import sram64_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int ACCESS_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              oe,
    output logic              show
);
    localparam int LOW_LEN = (ACCESS_CYCLES > 1) ? ACCESS_CYCLES - 1 : 1;
    localparam int CNT_W   = (LOW_LEN > 1) ? $clog2(LOW_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOW_LEN - 1);

    acc_state_t        state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic              moved;

    assign moved = (addr != hold_addr);
    assign we    = sel && !rd;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        addr_nx  = hold_addr;
        if (!sel) begin
            state_nx = ST_IDLE;
        end else if (!rd) begin
            state_nx = ST_WRITE;
        end else begin
            unique case (state)
                ST_IDLE, ST_WRITE: begin
                    state_nx = ST_RD_LOW;
                    cnt_nx   = '0;
                    addr_nx  = addr;
                end
                ST_RD_LOW: begin
                    if (moved) begin
                        cnt_nx  = '0;
                        addr_nx = addr;
                    end else if (cnt == CNT_LAST) begin
                        state_nx = ST_RD_DATA;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                ST_RD_DATA: begin
                    if (moved) begin
                        state_nx = ST_RD_LOW;
                        cnt_nx   = '0;
                        addr_nx  = addr;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            hold_addr <= '0;
        end else begin
            state     <= state_nx;
            cnt       <= cnt_nx;
            hold_addr <= addr_nx;
        end
    end

    always_comb begin
        oe   = 1'b0;
        show = 1'b0;
        unique case (state)
            ST_IDLE, ST_WRITE: begin
                oe   = 1'b0;
                show = 1'b0;
            end
            ST_RD_LOW: begin
                oe   = 1'b1;
                show = 1'b0;
            end
            ST_RD_DATA: begin
                oe   = 1'b1;
                show = 1'b1;
            end
        endcase
    end

    // R2
    idle_when_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !oe);
    // R4
    enable_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> $past(sel && rd));
    // R5
    low_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(show) |-> $past(oe) && !$past(show));
    // R8
    addr_held_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (show && $past(show)) |-> $stable(hold_addr));
    // R3
    write_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !oe);
endmodule

// File: rtl/strobed_ram64.sv
module strobed_ram64 #(
    parameter int ADDR_W        = 6,
    parameter int ACCESS_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe
);
    logic              sel, we, oe, show, rbit;
    logic [ADDR_W-1:0] hold_addr;

    assign sel = stb && en_a && en_b;

    sram64_ctrl #(.ADDR_W(ADDR_W), .ACCESS_CYCLES(ACCESS_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd_nwr), .addr(addr),
        .we(we), .hold_addr(hold_addr), .oe(oe), .show(show)
    );

    sram64_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(we), .waddr(addr), .wbit(din),
        .raddr(hold_addr), .rbit(rbit)
    );

    assign dout_oe = oe;
    assign dout    = show ? rbit : 1'b0;

    // R10
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);
endmodule

// File: tb/strobed_ram64_tb.sv
module strobed_ram64_tb;
    localparam int AC = 2;

    logic clk = 0, rst_n = 0;
    logic stb = 0, en_a = 0, en_b = 0, rd_nwr = 1, din = 0;
    logic [5:0] addr = 0;
    logic dout, dout_oe;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    strobed_ram64 #(.ADDR_W(6), .ACCESS_CYCLES(AC)) u_dut (
        .clk(clk), .rst_n(rst_n), .stb(stb), .en_a(en_a), .en_b(en_b),
        .rd_nwr(rd_nwr), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual oe/dout=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        stb = 0; en_a = 0; en_b = 0; step();
    endtask

    task automatic wr(input logic [5:0] a, input logic b);
        stb = 1; en_a = 1; en_b = 1; rd_nwr = 0; addr = a; din = b; step();
        chk("R3", {dout_oe, dout}, 2'b00);
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic b);
        stb = 1; en_a = 1; en_b = 1; rd_nwr = 1; addr = a;
        for (int i = 0; i < AC - 1; i++) begin
            step();
            chk("R5", {dout_oe, dout}, 2'b10);
        end
        step();
        chk(req, {dout_oe, dout}, {1'b1, b});
    endtask

    task automatic t_reset();
        #1;
        chk("R9", {dout_oe, dout}, 2'b00);
        step(); step();
        rst_n = 1;
        step();
        chk("R9", {dout_oe, dout}, 2'b00);
    endtask

    task automatic t_write_read();
        wr(6'd3, 1'b1); idle();
        chk("R4", {dout_oe, dout}, 2'b00);
        rd_check("R6", 6'd3, 1'b1); idle();
        wr(6'd3, 1'b0); idle();
        rd_check("R6", 6'd3, 1'b0); idle();
    endtask

    task automatic t_decode();
        for (int a = 0; a < 64; a++) wr(6'(a), ^(6'(a)) ^ a[3]);
        for (int a = 0; a < 64; a++) begin
            rd_check("R1", 6'(a), ^(6'(a)) ^ a[3]);
        end
        idle();
        chk("R2", {dout_oe, dout}, 2'b00);
    endtask

    task automatic t_qualifiers();
        wr(6'd9, 1'b1); idle();
        for (int q = 0; q < 3; q++) begin
            stb = (q != 0); en_a = (q != 1); en_b = (q != 2);
            rd_nwr = 0; addr = 6'd9; din = 0; step();
            chk("R2", {dout_oe, dout}, 2'b00);
            rd_nwr = 1; step();
            chk("R2", {dout_oe, dout}, 2'b00);
        end
        idle();
        rd_check("R2", 6'd9, 1'b1); idle();
    endtask

    task automatic t_restart();
        wr(6'd20, 1'b1); wr(6'd21, 1'b0); wr(6'd22, 1'b1);
        rd_check("R7", 6'd20, 1'b1);
        addr = 6'd22; step();
        chk("R8", {dout_oe, dout}, 2'b10);
        step();
        chk("R8", {dout_oe, dout}, 2'b11);
        addr = 6'd21; step();
        chk("R8", {dout_oe, dout}, 2'b10);
        addr = 6'd20; step();
        chk("R8", {dout_oe, dout}, 2'b10);
        step();
        chk("R8", {dout_oe, dout}, 2'b11);
        rd_nwr = 0; addr = 6'd21; din = 1; step();
        chk("R3", {dout_oe, dout}, 2'b00);
        idle();
        rd_check("R7", 6'd21, 1'b1); idle();
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_decode();
        t_qualifiers();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule